// File: doc/BRIEF.md
# UDP over IPv4 Ethernet Frame Generator

This block produces one complete Ethernet II frame carrying an IPv4 datagram with a UDP segment, presented as a stream of 32-bit words to the transmit port of a MAC. Addresses and ports are fixed by parameters. Per frame, only the payload length (taken from a size input when the frame is started) and the IP identification (a running count) change. The MAC appends the frame check sequence, so that field is not part of this block.

The IPv4 header checksum has to appear early in the header. The block therefore computes it before the first frame word goes out: it clears a ones'-complement accumulator, feeds it the five header words that carry information (one per clock), and then streams the frame. It places the folded and inverted result in the header. The UDP checksum is always sent as zero, which receivers treat as "no checksum". The payload is a run of 16-bit halfwords that count upward from 1.

A user drives `pkt_size` and pulses `start` while `busy` is low. The block then raises `out_valid` and advances one word for every cycle in which `out_ready` is high. The first word carries a start-of-frame flag. The last word carries an end-of-frame flag together with a code for the number of valid bytes in that word.

Top module: `udp_frame_gen`

## Requirements
- R1: Header words leave in this fixed order: dst MAC[47:16]; {dst MAC[15:0], src MAC[47:32]}; src MAC[31:0]; 0x0800_4500; {IP total length, identification}; {0x0000, 0x4011}; {header checksum, src IP[31:16]}; {src IP[15:0], dst IP[31:16]}; {dst IP[15:0], src port}; {dst port, UDP length}; {UDP checksum, payload halfword 0}.
- R2: The header checksum is the bitwise inverse of the end-around-carry sum of the ten header halfwords, with the checksum field counted as zero. Summing all ten halfwords including the sent checksum therefore folds to 0xFFFF.
- R3: The UDP checksum halfword is always 0x0000. The fragment field is 0x0000, the TTL is 0x40 and the protocol is 0x11.
- R4: With M = pkt_size (a value of 0 is treated as 1), the payload holds M halfwords. The IP total length is 28+2M and the UDP length is 8+2M.
- R5: Payload halfword k carries the value k+1. Halfword 0 sits in the low half of word 10. Later halfwords pack two per word (upper half first), and an unused low half in the last word is 0x0000.
- R6: out_flags bit 0 marks the first word only. Bit 1 marks the last word only. Bits 3:2 on the last word give the valid byte count modulo 4 (2'b00 = four bytes, 2'b10 = two bytes when M is even) and are zero on every other word. The frame has 11 + floor(M/2) words.
- R7: A word is consumed only on a clock edge where out_valid and out_ready are both high. While out_ready is low, out_valid, out_data and out_flags hold steady.
- R8: The identification is 0 for the first frame after reset and increases by one after each completed frame.
- R9: start is taken only while busy is low. busy is high from the cycle after start is taken until the cycle after the last word is consumed. A start (or a pkt_size change) while busy has no effect on the frame in flight or on the identification sequence.
- R10: A synchronous reset clears out_valid, out_flags and busy, and aborts any frame in progress.
- R11: out_valid first rises on the sixth clock edge after the edge that takes start (one clear cycle and five accumulate cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| pkt_size | input | SIZE_W | Payload length in 16-bit halfwords, sampled with start |
| busy | output | 1 | A frame is being prepared or sent |
| out_data | output | 32 | Frame word toward the MAC |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | MAC accepts the current word |
| out_flags | output | 4 | bit0 start of frame, bit1 end of frame, bits3:2 valid bytes mod 4 |

## Verification
The bench targets payload lengths of one halfword, where the frame ends on the word that carries the UDP checksum, and of even lengths, where the last word is half filled. A wrong end-index or byte code would show there as an extra word, a missing word or a four-byte claim on padding. Ready patterns with long stalls check that data and flags are held: a design that advanced without ready would skip words. A start pulse during the accumulate and send phases checks that a busy block neither restarts nor picks up a new size. Reset mid-frame checks that the identification returns to zero. An independent ones'-complement fold over the received header exposes any carry-handling error in the checksum.

// File: rtl/ufg_pkg.sv
package ufg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLR,
    ST_SUM,
    ST_SEND
  } ufg_state_e;

  localparam int HDR_WORDS  = 11;
  localparam int CSUM_WORDS = 5;
  localparam int FLG_SOF    = 0;
  localparam int FLG_EOF    = 1;
endpackage

// File: rtl/ufg_csum.sv
module ufg_csum #(
  parameter int NWORDS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        add,
  input  logic [31:0] word,
  output logic [15:0] csum
);
  localparam int ACC_W = 16 + $clog2(2 * NWORDS);

  logic [ACC_W-1:0] acc;
  logic [16:0]      fold1;
  logic [16:0]      fold2;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (add) begin
      acc <= acc + ACC_W'(word[31:16]) + ACC_W'(word[15:0]);
    end
  end

  always_comb begin
    fold1 = {1'b0, acc[15:0]} + 17'(acc[ACC_W-1:16]);
    fold2 = {1'b0, fold1[15:0]} + 17'(fold1[16]);
    csum  = ~fold2[15:0];
  end

  // R2: a cleared accumulator presents the inverse of zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (clr && !add) |=> (csum == 16'hFFFF));
endmodule

// File: rtl/ufg_word_sel.sv
module ufg_word_sel #(
  parameter logic [47:0] DST_MAC  = 48'h0211_2233_4455,
  parameter logic [47:0] SRC_MAC  = 48'h02AA_BBCC_DDEE,
  parameter logic [31:0] SRC_IP   = 32'hC0A8_0308,
  parameter logic [31:0] DST_IP   = 32'hC0A8_0304,
  parameter logic [15:0] SRC_PORT = 16'd12345,
  parameter logic [15:0] DST_PORT = 16'd23456,
  parameter int          SIZE_W   = 10,
  parameter int          WIDX_W   = SIZE_W + 1
) (
  input  logic [WIDX_W-1:0] idx,
  input  logic [SIZE_W-1:0] nhalf,
  input  logic [15:0]       tot_len,
  input  logic [15:0]       udp_len,
  input  logic [15:0]       ident,
  input  logic [15:0]       csum,
  output logic [31:0]       data,
  output logic [3:0]        flags
);
  logic [WIDX_W-1:0] last_idx;
  logic [WIDX_W:0]   hw_pos;
  logic [15:0]       hi_val;
  logic [15:0]       lo_val;
  logic              eof;

  always_comb begin
    last_idx = WIDX_W'(10) + WIDX_W'(nhalf >> 1);
    hw_pos   = {idx - WIDX_W'(11), 1'b0} + (WIDX_W+1)'(2);
    hi_val   = 16'(hw_pos);
    lo_val   = ((WIDX_W+1)'(nhalf) > hw_pos) ? 16'(hw_pos + 1'b1) : 16'h0000;
    case (idx)
      WIDX_W'(0):  data = DST_MAC[47:16];
      WIDX_W'(1):  data = {DST_MAC[15:0], SRC_MAC[47:32]};
      WIDX_W'(2):  data = SRC_MAC[31:0];
      WIDX_W'(3):  data = 32'h0800_4500;
      WIDX_W'(4):  data = {tot_len, ident};
      WIDX_W'(5):  data = 32'h0000_4011;
      WIDX_W'(6):  data = {csum, SRC_IP[31:16]};
      WIDX_W'(7):  data = {SRC_IP[15:0], DST_IP[31:16]};
      WIDX_W'(8):  data = {DST_IP[15:0], SRC_PORT};
      WIDX_W'(9):  data = {DST_PORT, udp_len};
      WIDX_W'(10): data = {16'h0000, 16'h0001};
      default:     data = {hi_val, lo_val};
    endcase
    eof   = (idx == last_idx);
    flags = {(eof && !nhalf[0]) ? 2'b10 : 2'b00, eof, idx == '0};
  end
endmodule

// File: rtl/udp_frame_gen.sv
module udp_frame_gen
  import ufg_pkg::*;
#(
  parameter logic [47:0] DST_MAC  = 48'h0211_2233_4455,
  parameter logic [47:0] SRC_MAC  = 48'h02AA_BBCC_DDEE,
  parameter logic [31:0] SRC_IP   = 32'hC0A8_0308,
  parameter logic [31:0] DST_IP   = 32'hC0A8_0304,
  parameter logic [15:0] SRC_PORT = 16'd12345,
  parameter logic [15:0] DST_PORT = 16'd23456,
  parameter int          SIZE_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] pkt_size,
  output logic              busy,
  output logic [31:0]       out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_flags
);
  localparam int WIDX_W = SIZE_W + 1;
  localparam int STEP_W = $clog2(CSUM_WORDS + 1);

  ufg_state_e        state;
  logic [STEP_W-1:0] step;
  logic [SIZE_W-1:0] nhalf_q;
  logic [15:0]       ident_q;
  logic [15:0]       tot_len;
  logic [15:0]       udp_len;
  logic [15:0]       csum;
  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] sel_idx;
  logic [31:0]       sel_data;
  logic [3:0]        sel_flags;
  logic [31:0]       sum_word;
  logic              accept;

  assign busy    = (state != ST_IDLE);
  assign accept  = out_valid && out_ready;
  assign tot_len = 16'd28 + 16'({nhalf_q, 1'b0});
  assign udp_len = 16'd8 + 16'({nhalf_q, 1'b0});
  assign sel_idx = (state == ST_SEND) ? widx + 1'b1 : '0;

  always_comb begin
    case (step)
      STEP_W'(0): sum_word = {16'h4500, tot_len};
      STEP_W'(1): sum_word = {ident_q, 16'h0000};
      STEP_W'(2): sum_word = {16'h4011, 16'h0000};
      STEP_W'(3): sum_word = SRC_IP;
      STEP_W'(4): sum_word = DST_IP;
      default:    sum_word = '0;
    endcase
  end

  ufg_csum #(.NWORDS(CSUM_WORDS)) i_csum (
    .clk  (clk),
    .rst  (rst),
    .clr  (state == ST_CLR),
    .add  (state == ST_SUM),
    .word (sum_word),
    .csum (csum)
  );

  ufg_word_sel #(
    .DST_MAC (DST_MAC),
    .SRC_MAC (SRC_MAC),
    .SRC_IP  (SRC_IP),
    .DST_IP  (DST_IP),
    .SRC_PORT(SRC_PORT),
    .DST_PORT(DST_PORT),
    .SIZE_W  (SIZE_W),
    .WIDX_W  (WIDX_W)
  ) i_word_sel (
    .idx    (sel_idx),
    .nhalf  (nhalf_q),
    .tot_len(tot_len),
    .udp_len(udp_len),
    .ident  (ident_q),
    .csum   (csum),
    .data   (sel_data),
    .flags  (sel_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      nhalf_q   <= SIZE_W'(1);
      ident_q   <= '0;
      widx      <= '0;
      out_data  <= '0;
      out_flags <= '0;
      out_valid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            nhalf_q <= (pkt_size == '0) ? SIZE_W'(1) : pkt_size;
            state   <= ST_CLR;
          end
        end
        ST_CLR: begin
          step  <= '0;
          state <= ST_SUM;
        end
        ST_SUM: begin
          step <= step + 1'b1;
          if (step == STEP_W'(CSUM_WORDS - 1)) begin
            state     <= ST_SEND;
            widx      <= '0;
            out_data  <= sel_data;
            out_flags <= sel_flags;
            out_valid <= 1'b1;
          end
        end
        ST_SEND: begin
          if (accept) begin
            if (out_flags[FLG_EOF]) begin
              out_valid <= 1'b0;
              out_flags <= '0;
              ident_q   <= ident_q + 1'b1;
              state     <= ST_IDLE;
            end else begin
              widx      <= widx + 1'b1;
              out_data  <= sel_data;
              out_flags <= sel_flags;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a stalled word stays put
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flags)));

  // R6: flags only travel with a valid word
  p_flags_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (out_flags != 4'b0000) |-> out_valid);

  // R9: a word is never shown while idle, and the end word returns to idle
  p_valid_busy_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
  p_eof_done_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && out_flags[FLG_EOF]) |=> (!out_valid && !busy));

  // R9: a busy block keeps its latched size
  p_size_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(nhalf_q));

  // R11: nothing reaches the MAC before the checksum is complete
  p_no_early_word_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLR || state == ST_SUM) |-> !out_valid);
endmodule

// File: tb/test_udp_frame_gen.sv
module test_udp_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE_W     = 10;
  localparam logic [47:0] T_DMAC  = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] T_SMAC  = 48'h0212_2232_4252;
  localparam logic [31:0] T_SIP   = 32'hC0A8_0103;
  localparam logic [31:0] T_DIP   = 32'hC0A8_0108;
  localparam logic [15:0] T_SPORT = 16'h1F90;
  localparam logic [15:0] T_DPORT = 16'h2328;

  localparam int NVEC = 6;
  localparam int          V_SIZE  [NVEC] = '{1, 2, 3, 7, 0, 12};
  localparam logic [7:0]  V_RDY   [NVEC] = '{8'hFF, 8'hAA, 8'h5B, 8'hFF, 8'h81, 8'h3C};
  localparam int          V_POKE  [NVEC] = '{-1, -1, 3, -1, -1, 20};
  localparam int          V_NW    [NVEC] = '{11, 12, 12, 14, 11, 17};
  localparam int          V_BYTES [NVEC] = '{4, 2, 4, 4, 4, 2};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [SIZE_W-1:0] pkt_size = '0;
  logic              busy;
  logic [31:0]       out_data;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [3:0]        out_flags;

  int          n_run = 0;
  int          n_fail = 0;
  logic [15:0] exp_ident = 16'h0000;
  logic [31:0] rx [32];

  always #(CLK_PERIOD / 2) clk = ~clk;

  udp_frame_gen #(
    .DST_MAC (T_DMAC),
    .SRC_MAC (T_SMAC),
    .SRC_IP  (T_SIP),
    .DST_IP  (T_DIP),
    .SRC_PORT(T_SPORT),
    .DST_PORT(T_DPORT),
    .SIZE_W  (SIZE_W)
  ) i_udp_frame_gen (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pkt_size (pkt_size),
    .busy     (busy),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_flags(out_flags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fold_sum(input int s_in);
    int s = s_in;
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return 16'(s);
  endfunction

  function automatic logic [15:0] ref_csum(input int m, input logic [15:0] id);
    int s = 32'h4500 + (28 + 2 * m) + int'(id) + 32'h4011
            + int'(T_SIP[31:16]) + int'(T_SIP[15:0])
            + int'(T_DIP[31:16]) + int'(T_DIP[15:0]);
    return ~fold_sum(s);
  endfunction

  function automatic logic [31:0] ref_word(input int idx, input int m, input logic [15:0] id);
    logic [15:0] tot = 16'(28 + 2 * m);
    logic [15:0] ul  = 16'(8 + 2 * m);
    int p, q;
    case (idx)
      0:  return T_DMAC[47:16];
      1:  return {T_DMAC[15:0], T_SMAC[47:32]};
      2:  return T_SMAC[31:0];
      3:  return 32'h0800_4500;
      4:  return {tot, id};
      5:  return 32'h0000_4011;
      6:  return {ref_csum(m, id), T_SIP[31:16]};
      7:  return {T_SIP[15:0], T_DIP[31:16]};
      8:  return {T_DIP[15:0], T_SPORT};
      9:  return {T_DPORT, ul};
      10: return 32'h0000_0001;
      default: begin
        p = 2 * (idx - 11) + 1;
        q = p + 1;
        return {16'(p + 1), (q < m) ? 16'(q + 1) : 16'h0000};
      end
    endcase
  endfunction

  task automatic start_frame(input int size);
    @(negedge clk);
    pkt_size = SIZE_W'(size);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy == 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
  endtask

  task automatic collect(input int size, input logic [7:0] pat, input int nw,
                         input int nbytes, input int lim, input int poke,
                         input bit first_valid);
    int m = (size == 0) ? 1 : size;
    int n = 0;
    int cyc = 0;
    bit held = 1'b0;
    logic [31:0] hd = '0;
    logic [3:0]  hf = '0;
    logic [3:0]  ef;
    int s;
    while (n < lim && cyc < 4000) begin
      @(negedge clk);
      out_ready = pat[cyc % 8];
      if (cyc == poke) begin
        start    = 1'b1;
        pkt_size = SIZE_W'(5);
      end else begin
        start = 1'b0;
      end
      #1;
      if (first_valid && cyc == 0)
        check(out_valid == 1'b1, "R11", "first word after six edges", 32'(out_valid), 32'd1);
      if (held)
        check(out_valid && out_data == hd && out_flags == hf, "R7", "word held while stalled",
              out_data, hd);
      held = out_valid && !out_ready;
      hd   = out_data;
      hf   = out_flags;
      if (out_valid && out_ready) begin
        ef = {(n == nw - 1 && nbytes == 2) ? 2'b10 : 2'b00, n == nw - 1, n == 0};
        check(out_data == ref_word(n, m, exp_ident), (n <= 10) ? "R1" : "R5",
              $sformatf("word %0d", n), out_data, ref_word(n, m, exp_ident));
        check(out_flags == ef, "R6", $sformatf("flags of word %0d", n), 32'(out_flags), 32'(ef));
        if (n < 32) rx[n] = out_data;
        n++;
      end
      cyc++;
    end
    start = 1'b0;
    if (lim == nw) begin
      @(negedge clk);
      out_ready = 1'b0;
      #1;
      check(!busy && !out_valid, "R9", "idle after last word", {busy, out_valid}, 32'd0);
      s = int'(rx[3][15:0]) + int'(rx[4][31:16]) + int'(rx[4][15:0]) + int'(rx[5][31:16])
        + int'(rx[5][15:0]) + int'(rx[6][31:16]) + int'(rx[6][15:0]) + int'(rx[7][31:16])
        + int'(rx[7][15:0]) + int'(rx[8][31:16]);
      check(fold_sum(s) == 16'hFFFF, "R2", "header folds to all ones", 32'(fold_sum(s)), 32'hFFFF);
      check(rx[4][31:16] == 16'(28 + 2 * m) && rx[9][15:0] == 16'(8 + 2 * m), "R4",
            "IP and UDP lengths", {rx[4][31:16], rx[9][15:0]}, {16'(28 + 2 * m), 16'(8 + 2 * m)});
      check(rx[5] == 32'h0000_4011 && rx[10][31:16] == 16'h0000, "R3",
            "fragment/ttl/protocol and zero UDP checksum", rx[10], 32'h0000_0001);
      check(rx[4][15:0] == exp_ident, "R8", "identification", 32'(rx[4][15:0]), 32'(exp_ident));
      exp_ident = exp_ident + 16'd1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && out_flags == 4'b0 && !busy, "R10", "state during reset",
          {out_valid, out_flags, busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && out_flags == 4'b0 && !busy, "R10", "idle after reset",
          {out_valid, out_flags, busy}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      start_frame(V_SIZE[v]);
      collect(V_SIZE[v], V_RDY[v], V_NW[v], V_BYTES[v], V_NW[v], V_POKE[v], 1'b0);
    end

    // R11: latency from accepted start to the first word
    @(negedge clk);
    out_ready = 1'b1;
    start_frame(4);
    for (int i = 2; i <= 6; i++) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R11", $sformatf("no word yet at edge %0d", i), 32'(out_valid), 32'd0);
    end
    collect(4, 8'hFF, 13, 2, 13, -1, 1'b1);

    // R10: reset part way through a frame
    start_frame(9);
    collect(9, 8'hFF, 15, 4, 4, -1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && out_flags == 4'b0 && !busy, "R10", "reset aborts frame",
          {out_valid, out_flags, busy}, 32'd0);
    rst = 1'b0;
    exp_ident = 16'h0000;
    start_frame(3);
    collect(3, 8'h6D, 12, 4, 12, -1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule